// File: doc/BRIEF.md
# LCD Bias Fast-Charge Controller

This block steps a multiplexed LCD through its backplane phases and decides, cycle by cycle, whether the bias resistor ladder runs in its high-current or low-current setting. A periodic base-clock tick advances the active backplane. The number of backplanes in one frame is set by a duty input, so one frame lasts one tick period times that number. For example, three backplanes at a 256 Hz tick give a frame of about 11.72 ms. Each tick is a waveform switching edge, and the block reports it as a one-cycle pulse.

The ladder select works in one of three ways. It can hold high current all the time, or low current all the time. In fast-charge mode it instead gives a timed burst of high current that starts at every switching edge and returns to low current once a programmable number of LCD clock periods has passed. The LCD clock is given as a one-cycle enable on the system clock. The analog ladder, the segment data and any register bus lie outside the block, and its control bits are plain inputs.

Top module: `lcd_bias_ctrl`

## Requirements
- R1: While `rst` is high, at the next clock edge `bp_idx` becomes 0, `wave_edge` becomes 0, `hi_cur` becomes 0 (low current) and the burst counter is cleared.
- R2: `bp_idx` changes only in the cycle after a `base_tick`. It then steps from 0 up to `duty_sel` and returns to 0 on the tick after it reaches `duty_sel`. `duty_sel` encodes the number of backplanes minus one: 0 means 1/1, 1 means 1/2, 2 means 1/3 and 3 means 1/4.
- R3: `wave_edge` is high for exactly the one cycle after each `base_tick`, including the first tick after reset is released, and is low at all other times.
- R4: With `fast_chg`=0 and `low_cur`=0, `hi_cur` is 1 in every cycle after reset is released.
- R5: With `fast_chg`=0 and `low_cur`=1, `hi_cur` is 0 in every cycle after reset is released.
- R6: With `fast_chg`=1, `hi_cur` becomes 1 in the cycle after each `base_tick`.
- R7: In fast-charge mode, after a tick `hi_cur` stays 1 for exactly N `lcd_clk_en` pulses and then returns to 0. N is 32 when `fc_len`=0, 64 when `fc_len`=1 and 128 when `fc_len`=2.
- R8: `fc_len`=3 gives the same burst length as 2, which is 128 LCD clock pulses.
- R9: A `base_tick` that arrives during a burst restarts the burst at its full length.
- R10: With `fast_chg`=1, `low_cur` has no effect. Between bursts `hi_cur` is 0 even when `low_cur`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| lcd_clk_en | input | 1 | One-cycle enable, one per LCD clock period |
| base_tick | input | 1 | Waveform base-clock tick, one cycle wide |
| duty_sel | input | 2 | Number of backplanes minus one |
| low_cur | input | 1 | Selects the low-current ladder when fast charge is off |
| fast_chg | input | 1 | Enables timed high-current bursts on switching edges |
| fc_len | input | 2 | Burst length code: 32, 64 or 128 LCD clock periods (3 = 128) |
| bp_idx | output | 2 | Active backplane index |
| wave_edge | output | 1 | One-cycle pulse after each switching edge |
| hi_cur | output | 1 | 1 selects the high-current ladder, 0 the low-current ladder |

## Verification
The range check on the phase index assumes that `duty_sel` is sampled at each tick. The stimulus holds `duty_sel` steady within each phase-sequence scenario and changes it only while reset is asserted. The burst-length checks assume that `fc_len` and `fast_chg` do not change during a burst, so the bench sets them before it issues a tick. The bench runs the burst checks with `lcd_clk_en` pulsing every cycle and again with it pulsing every second cycle, so that the count follows the LCD clock and not the system clock. Ticks are spaced well apart from one another, except in the restart scenario.

// File: rtl/lcd_bias_pkg.sv
package lcd_bias_pkg;
  // Burst length in LCD clock periods for a 2-bit code; code 3 aliases code 2.
  function automatic int unsigned fc_periods(input logic [1:0] code, input int unsigned base);
    case (code)
      2'd0:    fc_periods = base;
      2'd1:    fc_periods = base * 2;
      default: fc_periods = base * 4;
    endcase
  endfunction
endpackage

// File: rtl/lcd_phase_seq.sv
module lcd_phase_seq #(
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             base_tick,
  input  logic [IDX_W-1:0] duty_sel,
  output logic [IDX_W-1:0] bp_idx,
  output logic             wave_edge
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bp_idx    <= '0;
      wave_edge <= 1'b0;
    end else begin
      wave_edge <= base_tick;
      if (base_tick) begin
        if (bp_idx >= duty_sel) bp_idx <= '0;
        else                    bp_idx <= bp_idx + 1'b1;
      end
    end
  end

  // R2
  bp_idx_range_chk: assert property (@(posedge clk) disable iff (rst)
    base_tick |=> (bp_idx <= $past(duty_sel)));

  // R2
  bp_idx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !base_tick |=> $stable(bp_idx));

  // R3
  wave_edge_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    base_tick |=> wave_edge);

  // R3
  wave_edge_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !base_tick |=> !wave_edge);
endmodule

// File: rtl/lcd_fc_timer.sv
module lcd_fc_timer
  import lcd_bias_pkg::*;
#(
  parameter int FC_BASE = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic lcd_clk_en,
  input  logic base_tick,
  input  logic fast_chg,
  input  logic [1:0] fc_len,
  output logic burst_nxt
);
  localparam int MAX_LEN = FC_BASE * 4;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d, load_val;

  always_comb begin
    load_val = CNT_W'(fc_periods(fc_len, FC_BASE));
    cnt_d    = cnt_q;
    if (!fast_chg)                       cnt_d = '0;
    else if (base_tick)                  cnt_d = load_val;
    else if (lcd_clk_en && cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  assign burst_nxt = (cnt_d != '0);

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  // R7
  cnt_limit_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(MAX_LEN));

  // R9
  cnt_reload_chk: assert property (@(posedge clk) disable iff (rst)
    (fast_chg && base_tick) |=> (cnt_q >= CNT_W'(FC_BASE)));

  // R7
  cnt_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!lcd_clk_en && !base_tick && fast_chg) |=> $stable(cnt_q));
endmodule

// File: rtl/lcd_bias_ctrl.sv
module lcd_bias_ctrl #(
  parameter int IDX_W   = 2,
  parameter int FC_BASE = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lcd_clk_en,
  input  logic             base_tick,
  input  logic [IDX_W-1:0] duty_sel,
  input  logic             low_cur,
  input  logic             fast_chg,
  input  logic [1:0]       fc_len,
  output logic [IDX_W-1:0] bp_idx,
  output logic             wave_edge,
  output logic             hi_cur
);
  logic burst_nxt;

  lcd_phase_seq #(.IDX_W(IDX_W)) u_phase (
    .clk(clk), .rst(rst), .base_tick(base_tick), .duty_sel(duty_sel),
    .bp_idx(bp_idx), .wave_edge(wave_edge)
  );

  lcd_fc_timer #(.FC_BASE(FC_BASE)) u_timer (
    .clk(clk), .rst(rst), .lcd_clk_en(lcd_clk_en), .base_tick(base_tick),
    .fast_chg(fast_chg), .fc_len(fc_len), .burst_nxt(burst_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst)           hi_cur <= 1'b0;
    else if (fast_chg) hi_cur <= burst_nxt;
    else               hi_cur <= !low_cur;
  end

  // R4
  static_high_chk: assert property (@(posedge clk) disable iff (rst)
    (!fast_chg && !low_cur) |=> hi_cur);

  // R5
  static_low_chk: assert property (@(posedge clk) disable iff (rst)
    (!fast_chg && low_cur) |=> !hi_cur);

  // R6
  burst_start_chk: assert property (@(posedge clk) disable iff (rst)
    (fast_chg && base_tick) |=> hi_cur);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!hi_cur && !wave_edge && bp_idx == '0));
endmodule

// File: tb/lcd_bias_ctrl_bench.sv
module lcd_bias_ctrl_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lcd_clk_en = 1'b1, base_tick = 1'b0, low_cur = 1'b0, fast_chg = 1'b0;
  logic [1:0] duty_sel = 2'd0, fc_len = 2'd0;
  logic [1:0] bp_idx;
  logic wave_edge, hi_cur;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  lcd_bias_ctrl u_lcd_bias_ctrl (
    .clk(clk), .rst(rst), .lcd_clk_en(lcd_clk_en), .base_tick(base_tick),
    .duty_sel(duty_sel), .low_cur(low_cur), .fast_chg(fast_chg), .fc_len(fc_len),
    .bp_idx(bp_idx), .wave_edge(wave_edge), .hi_cur(hi_cur)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset;
    @(negedge clk); rst = 1'b1; base_tick = 1'b0;
    idle(2); rst = 1'b0;
  endtask

  task automatic tick;
    @(negedge clk); base_tick = 1'b1;
    @(negedge clk); base_tick = 1'b0;
  endtask

  // R1: state while reset is held
  task automatic t_reset;
    @(negedge clk); rst = 1'b1; low_cur = 1'b0; fast_chg = 1'b0;
    idle(2);
    check("R1 bp_idx", bp_idx, 0);
    check("R1 wave_edge", wave_edge, 0);
    check("R1 hi_cur", hi_cur, 0);
    rst = 1'b0;
    idle(3);
  endtask

  // R2/R3: phase stepping for a given duty code
  task automatic t_phase(input logic [1:0] d);
    @(negedge clk); rst = 1'b1; duty_sel = d; idle(2); rst = 1'b0;
    idle(2);
    for (int k = 1; k <= 2 * (d + 1) + 1; k++) begin
      @(negedge clk); base_tick = 1'b1;
      @(negedge clk); base_tick = 1'b0;
      check("R3 edge pulse", wave_edge, 1);
      check("R2 bp_idx", bp_idx, k % (d + 1));
      @(negedge clk);
      check("R3 edge single", wave_edge, 0);
      check("R2 bp_idx hold", bp_idx, k % (d + 1));
    end
  endtask

  // R4/R5: static current modes ignore ticks
  task automatic t_static;
    fast_chg = 1'b0; low_cur = 1'b0; do_reset; idle(1);
    tick; idle(3);
    check("R4 high hold", hi_cur, 1);
    low_cur = 1'b1; idle(2);
    tick;
    check("R5 low after tick", hi_cur, 0);
    idle(5);
    check("R5 low hold", hi_cur, 0);
  endtask

  // R6/R7/R8: burst length counted in lcd_clk_en pulses
  task automatic t_burst(input logic [1:0] code, input int exp, input bit slow, input string req);
    int n_en;
    bit ph;
    fast_chg = 1'b1; low_cur = 1'b1; fc_len = code; lcd_clk_en = 1'b1;
    do_reset; idle(2);
    check({req, " idle low"}, hi_cur, 0);
    n_en = 0; ph = 1'b0;
    @(negedge clk); base_tick = 1'b1;
    @(negedge clk); base_tick = 1'b0;
    check("R6 burst start", hi_cur, 1);
    for (int i = 0; i < 1000; i++) begin
      if (!hi_cur) break;
      ph = ~ph;
      lcd_clk_en = slow ? ph : 1'b1;
      if (lcd_clk_en) n_en++;
      @(negedge clk);
    end
    lcd_clk_en = 1'b1;
    check({req, " burst length"}, n_en, exp);
    idle(3);
    check({req, " back to low"}, hi_cur, 0);
  endtask

  // R9: tick in the middle of a burst restarts it
  task automatic t_restart;
    int n;
    fast_chg = 1'b1; fc_len = 2'd0; lcd_clk_en = 1'b1; do_reset; idle(2);
    tick; idle(19);
    tick;
    n = 0;
    while (hi_cur && n < 1000) begin n++; @(negedge clk); end
    check("R9 restarted length", n, 32);
  endtask

  // R10: low_cur=0 has no effect in fast-charge mode
  task automatic t_override;
    fast_chg = 1'b1; low_cur = 1'b0; fc_len = 2'd0; lcd_clk_en = 1'b1;
    do_reset; idle(2);
    check("R10 idle low", hi_cur, 0);
    tick; idle(40);
    check("R10 steady low", hi_cur, 0);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset;
    t_phase(2'd0);
    t_phase(2'd1);
    t_phase(2'd2);
    t_phase(2'd3);
    t_static;
    t_burst(2'd0, 32, 1'b0, "R7 len32");
    t_burst(2'd1, 64, 1'b0, "R7 len64");
    t_burst(2'd2, 128, 1'b0, "R7 len128");
    t_burst(2'd3, 128, 1'b0, "R8 reserved");
    t_burst(2'd1, 64, 1'b1, "R7 slow enable");
    t_restart;
    t_override;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule